// File: doc/BRIEF.md
# Daisy-Chained Serial Slot Controller

This block lets several devices take turns on one shared serial bus. The devices are linked in a chain by a carry token. When a device sees a rising edge on its carry input, it opens a transfer window of either 8 or 256 bit periods. In each bit period it drives one receive data bit and one receive signalling bit onto the bus. On each rising system clock edge it also captures one transmit data bit and one transmit signalling bit. When the window closes, the block releases the bus and raises its carry output, which starts the next device in the chain.

The bits to send come from two parallel buffers that the block loads just before the first bit. The captured bits are gathered into two matching parallel buffers, which are flagged valid when the window ends. Outside a window the receive pins are in high impedance, and an enable output shows whether the block is driving them.

Top module: `chain_slot_ctrl`

## Requirements
- R1: The carry input passes through a two-flop synchroniser and then an edge detector. If carry_in is raised between clock edges E0 and E1, rx_oe first reads high after edge E3. A level held steady, high or low, never starts a window.
- R2: The window length is latched when the window starts: 8 bits when len_sel is 0 and 256 bits when len_sel is 1. A change to len_sel during a window has no effect until the next window.
- R3: rx_oe is high only during a window. While rx_oe is low, rx_ser and rx_sig are in high impedance.
- R4: Bits go out least significant first. In bit period k (counting from 0), rx_ser equals rx_data_buf[k] and rx_sig equals rx_sig_buf[k].
- R5: The rising clock edge that ends bit period k stores tx_ser into tx_data[k] and tx_sig into tx_sig_data[k]. All buffer bits at or above the window length read 0.
- R6: carry_out rises on the same clock edge that rx_oe falls, right after the last bit period. It stays high until the next window starts. It is never high while rx_oe is high.
- R7: tx_valid rises together with carry_out and is cleared when the next window starts.
- R8: A carry-input rising edge that arrives while a window is open is ignored. No new window follows it.
- R9: A synchronous active-high reset drives rx_oe, carry_out and tx_valid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| carry_in | input | 1 | Token from the previous device (asynchronous) |
| len_sel | input | 1 | Window length: 0 = 8 bits, 1 = 256 bits |
| rx_data_buf | input | 256 | Receive data bits to send, bit 0 first |
| rx_sig_buf | input | 256 | Receive signalling bits to send, bit 0 first |
| tx_ser | input | 1 | Transmit data bit sampled from the bus |
| tx_sig | input | 1 | Transmit signalling bit sampled from the bus |
| rx_ser | output | 1 | Receive data onto the bus, high impedance when idle |
| rx_sig | output | 1 | Receive signalling onto the bus, high impedance when idle |
| rx_oe | output | 1 | High while the receive pins are driven |
| carry_out | output | 1 | Token to the next device |
| tx_data | output | 256 | Captured transmit data bits |
| tx_sig_data | output | 256 | Captured transmit signalling bits |
| tx_valid | output | 1 | Capture buffers are complete |

## Verification
Two things can happen in the same cycle: a new carry-input edge can arrive while the bit counter is still running, and the counter can reach its last bit, which hands the token on. The bench forces the first case by dropping carry_in and raising it again in the middle of a 256-bit window. Once the window has closed, it checks that rx_oe stays low and carry_out stays high for several cycles. It also flips len_sel partway through an 8-bit window and checks that the scoreboard receives exactly eight bits before the hand-off.

// File: rtl/chain_slot_pkg.sv
package chain_slot_pkg;
  localparam int unsigned DEF_SHORT_LEN = 8;
  localparam int unsigned DEF_LONG_LEN  = 256;

  typedef enum logic {
    WIN_SHORT = 1'b0,
    WIN_LONG  = 1'b1
  } win_len_e;
endpackage

// File: rtl/cs_carry_sync.sv
module cs_carry_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sync_q[g] <= 1'b0;
          else     sync_q[g] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sync_q[g] <= 1'b0;
          else     sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sync_q[STAGES-1];
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/cs_bit_counter.sv
module cs_bit_counter
  import chain_slot_pkg::*;
#(
  parameter int unsigned SHORT_LEN = DEF_SHORT_LEN,
  parameter int unsigned LONG_LEN  = DEF_LONG_LEN,
  localparam int unsigned CNT_W    = $clog2(LONG_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_req,
  input  win_len_e         len_sel,
  output logic             start_o,
  output logic             active_o,
  output logic             last_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_LEN - 1);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_LEN - 1);

  logic             active_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_idx_q;

  assign start_o  = start_req & ~active_q;
  assign active_o = active_q;
  assign cnt_o    = cnt_q;
  assign last_o   = active_q && (cnt_q == last_idx_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q   <= 1'b0;
      cnt_q      <= '0;
      last_idx_q <= SHORT_LAST;
    end else if (start_o) begin
      active_q   <= 1'b1;
      cnt_q      <= '0;
      last_idx_q <= (len_sel == WIN_LONG) ? LONG_LAST : SHORT_LAST;
    end else if (last_o) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (active_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/cs_rx_shifter.sv
module cs_rx_shifter #(
  parameter int unsigned LEN = 256
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic           shift,
  input  logic [LEN-1:0] data_buf,
  input  logic [LEN-1:0] sig_buf,
  output logic           data_o,
  output logic           sig_o
);
  logic [LEN-1:0] data_sh;
  logic [LEN-1:0] sig_sh;
  logic           data_q;
  logic           sig_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_sh <= '0;
      sig_sh  <= '0;
      data_q  <= 1'b0;
      sig_q   <= 1'b0;
    end else if (load) begin
      data_q  <= data_buf[0];
      sig_q   <= sig_buf[0];
      data_sh <= {1'b0, data_buf[LEN-1:1]};
      sig_sh  <= {1'b0, sig_buf[LEN-1:1]};
    end else if (shift) begin
      data_q  <= data_sh[0];
      sig_q   <= sig_sh[0];
      data_sh <= {1'b0, data_sh[LEN-1:1]};
      sig_sh  <= {1'b0, sig_sh[LEN-1:1]};
    end
  end

  assign data_o = data_q;
  assign sig_o  = sig_q;
endmodule

// File: rtl/cs_tx_collector.sv
module cs_tx_collector #(
  parameter int unsigned LEN = 256,
  localparam int unsigned IDX_W = $clog2(LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             capture,
  input  logic [IDX_W-1:0] idx,
  input  logic             data_in,
  input  logic             sig_in,
  output logic [LEN-1:0]   data_o,
  output logic [LEN-1:0]   sig_o
);
  logic [LEN-1:0] data_acc;
  logic [LEN-1:0] sig_acc;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      data_acc <= '0;
      sig_acc  <= '0;
    end else if (capture) begin
      data_acc[idx] <= data_in;
      sig_acc[idx]  <= sig_in;
    end
  end

  assign data_o = data_acc;
  assign sig_o  = sig_acc;
endmodule

// File: rtl/chain_slot_ctrl.sv
module chain_slot_ctrl
  import chain_slot_pkg::*;
#(
  parameter int unsigned SHORT_LEN   = DEF_SHORT_LEN,
  parameter int unsigned LONG_LEN    = DEF_LONG_LEN,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CNT_W      = $clog2(LONG_LEN)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                carry_in,
  input  logic                len_sel,
  input  logic [LONG_LEN-1:0] rx_data_buf,
  input  logic [LONG_LEN-1:0] rx_sig_buf,
  input  logic                tx_ser,
  input  logic                tx_sig,
  output wire                 rx_ser,
  output wire                 rx_sig,
  output logic                rx_oe,
  output logic                carry_out,
  output logic [LONG_LEN-1:0] tx_data,
  output logic [LONG_LEN-1:0] tx_sig_data,
  output logic                tx_valid
);
  logic             carry_rise;
  logic             win_start;
  logic             win_active;
  logic             win_last;
  logic [CNT_W-1:0] bit_idx;
  logic             data_bit;
  logic             sig_bit;
  logic             oe_q;
  logic             carry_q;
  logic             valid_q;

  cs_carry_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (carry_in),
    .rise_o   (carry_rise)
  );

  cs_bit_counter #(.SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .start_req (carry_rise),
    .len_sel   (win_len_e'(len_sel)),
    .start_o   (win_start),
    .active_o  (win_active),
    .last_o    (win_last),
    .cnt_o     (bit_idx)
  );

  cs_rx_shifter #(.LEN(LONG_LEN)) u_rx (
    .clk      (clk),
    .rst      (rst),
    .load     (win_start),
    .shift    (win_active & ~win_last),
    .data_buf (rx_data_buf),
    .sig_buf  (rx_sig_buf),
    .data_o   (data_bit),
    .sig_o    (sig_bit)
  );

  cs_tx_collector #(.LEN(LONG_LEN)) u_tx (
    .clk     (clk),
    .rst     (rst),
    .clear   (win_start),
    .capture (win_active),
    .idx     (bit_idx),
    .data_in (tx_ser),
    .sig_in  (tx_sig),
    .data_o  (tx_data),
    .sig_o   (tx_sig_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q    <= 1'b0;
      carry_q <= 1'b0;
      valid_q <= 1'b0;
    end else if (win_start) begin
      oe_q    <= 1'b1;
      carry_q <= 1'b0;
      valid_q <= 1'b0;
    end else if (win_last) begin
      oe_q    <= 1'b0;
      carry_q <= 1'b1;
      valid_q <= 1'b1;
    end
  end

  assign rx_oe     = oe_q;
  assign carry_out = carry_q;
  assign tx_valid  = valid_q;
  assign rx_ser    = oe_q ? data_bit : 1'bz;
  assign rx_sig    = oe_q ? sig_bit  : 1'bz;
endmodule

// File: rtl/chain_slot_chk.sv
module chain_slot_chk #(
  parameter int unsigned SHORT_LEN = 8,
  parameter int unsigned LONG_LEN  = 256,
  localparam int unsigned RUN_W    = $clog2(LONG_LEN + 2)
) (
  input logic clk,
  input logic rst,
  input logic rx_oe,
  input logic carry_out,
  input logic tx_valid
);
  logic [RUN_W-1:0] run_len;

  always_ff @(posedge clk) begin
    if (rst)        run_len <= '0;
    else if (rx_oe) run_len <= run_len + 1'b1;
    else            run_len <= '0;
  end

  p_len_choice_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(rx_oe) |-> (run_len == RUN_W'(SHORT_LEN) || run_len == RUN_W'(LONG_LEN)));

  p_oe_carry_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(rx_oe && carry_out));

  p_handoff_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(rx_oe) |-> $rose(carry_out));

  p_valid_with_carry_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_valid) |-> $rose(carry_out));

  p_start_clears_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_oe) |-> (!carry_out && !tx_valid));

  p_reset_idle_r9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!rx_oe && !carry_out && !tx_valid));
endmodule

bind chain_slot_ctrl chain_slot_chk #(.SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .rx_oe     (rx_oe),
  .carry_out (carry_out),
  .tx_valid  (tx_valid)
);

// File: tb/chain_slot_ctrl_tb.sv
module chain_slot_ctrl_tb;
  localparam int unsigned LONG = 256;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            carry_in = 1'b0;
  logic            len_sel = 1'b0;
  logic [LONG-1:0] rx_data_buf = '0;
  logic [LONG-1:0] rx_sig_buf = '0;
  logic            tx_ser = 1'b0;
  logic            tx_sig = 1'b0;
  wire             rx_ser;
  wire             rx_sig;
  logic            rx_oe;
  logic            carry_out;
  logic [LONG-1:0] tx_data;
  logic [LONG-1:0] tx_sig_data;
  logic            tx_valid;

  int n_chk = 0;
  int n_bad = 0;
  logic [1:0] exp_q[$];

  always #5 clk = ~clk;

  chain_slot_ctrl u_dut (
    .clk(clk), .rst(rst), .carry_in(carry_in), .len_sel(len_sel),
    .rx_data_buf(rx_data_buf), .rx_sig_buf(rx_sig_buf),
    .tx_ser(tx_ser), .tx_sig(tx_sig), .rx_ser(rx_ser), .rx_sig(rx_sig),
    .rx_oe(rx_oe), .carry_out(carry_out), .tx_data(tx_data),
    .tx_sig_data(tx_sig_data), .tx_valid(tx_valid)
  );

  task automatic chk(string req, logic [LONG-1:0] act, logic [LONG-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Monitor: R3/R4 bits popped from the scoreboard while driven
  always @(negedge clk) begin
    if (!rst && rx_oe) begin
      if (exp_q.size() == 0) begin
        chk("R2 extra bit", 1, 0);
      end else begin
        logic [1:0] e;
        e = exp_q.pop_front();
        chk("R4 rx bit", {254'b0, rx_ser, rx_sig}, {254'b0, e});
      end
    end
  end

  task automatic run_seq(bit lsel, logic [LONG-1:0] d, logic [LONG-1:0] s,
                         logic [LONG-1:0] t, logic [LONG-1:0] ts,
                         bit glitch, bit flip);
    int len = lsel ? 256 : 8;
    int lat = 0;
    logic [LONG-1:0] msk = lsel ? '1 : {{(LONG-8){1'b0}}, 8'hFF};
    for (int k = 0; k < len; k++) exp_q.push_back({d[k], s[k]});
    @(negedge clk);
    len_sel = lsel; rx_data_buf = d; rx_sig_buf = s; carry_in = 1'b1;
    do begin
      @(negedge clk);
      lat++;
    end while (!rx_oe && lat < 10);
    chk("R1 start latency", lat, 3);
    chk("R7 carry/valid cleared at start", {carry_out, tx_valid}, 0);
    for (int k = 0; k < len; k++) begin
      tx_ser = t[k]; tx_sig = ts[k];
      if (flip && k == 3) len_sel = ~lsel;
      if (glitch && k == 20) carry_in = 1'b0;
      if (glitch && k == 25) carry_in = 1'b1;
      @(negedge clk);
    end
    chk("R6 oe low after last bit", rx_oe, 0);
    chk("R6 carry_out high", carry_out, 1);
    chk("R7 tx_valid high", tx_valid, 1);
    chk("R2 all bits delivered", exp_q.size(), 0);
    chk("R5 tx data", tx_data, t & msk);
    chk("R5 tx sig", tx_sig_data, ts & msk);
    repeat (6) @(negedge clk);
    chk(glitch ? "R8 no restart" : "R1 level no restart", {rx_oe, carry_out}, 2'b01);
    carry_in = 1'b0;
    len_sel = lsel;
    repeat (3) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 reset state", {rx_oe, carry_out, tx_valid}, 0);
    chk("R3 idle oe low", rx_oe, 0);
    run_seq(1'b0, {8{32'hA5C3_1E77}}, {8{32'h0F0F_3C96}},
            {8{32'h5A5A_C3C3}}, {8{32'h1234_ABCD}}, 1'b0, 1'b0);
    run_seq(1'b1, {8{32'h9E37_79B9}}, {8{32'h7F4A_7C15}},
            {8{32'hDEAD_BEEF}}, {8{32'h0BAD_F00D}}, 1'b1, 1'b0);
    run_seq(1'b0, {8{32'h0000_00C6}}, {8{32'h0000_0039}},
            '1, {8{32'h0000_00A5}}, 1'b0, 1'b1);
    run_seq(1'b1, ~{8{32'h9E37_79B9}}, {8{32'hFFFF_0000}},
            {8{32'h8001_7FFE}}, '0, 1'b0, 1'b0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R9 reset clears carry", {rx_oe, carry_out, tx_valid}, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule